// File: doc/BRIEF.md
# Panel Sync and Active-Window Generator

This block drives the timing inputs of an analog-input colour TFT panel with 960 x 234 dots when the panel is run from an external clock. One free-running input clock advances a horizontal counter and a vertical counter. From these the block derives an active-low horizontal sync, an active-low vertical sync, and flags with position counters that mark the horizontal and vertical windows the panel actually shows. A video source uses the flags and positions to decide when to present each sample.

Two clocking modes exist. In dot mode each clock carries one colour component, so a line holds 960 active samples. In pixel mode the three components are sampled together, so a line holds 320 active samples. The two modes differ in line length and active window. The mode request is taken only when one frame ends and the next begins, so no frame mixes the two modes. Line length for each mode, frame length, horizontal sync width and vertical sync width can be written at run time. Each written value is clamped into its legal range.

The panel samples horizontal sync on the clock rising edge, and vertical sync on the rising edge of horizontal sync. For that reason every vertical sync transition happens in the middle of a line, far from any horizontal sync edge. All outputs come straight from flip-flops.

Top module: `panel_timing_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after any cycle with `rst` high, the outputs hold their reset values: `hsy_n` = 1, `vsy_n` = 1, `h_active` = 0, `v_active` = 0, `x_pos` = 0, `y_pos` = 0. Reset also restores every configuration value to its nominal value.
- R2: The time between two falling edges of `hsy_n` equals the line length of the current mode. The nominal values are 1200 clocks in dot mode (`pix_mode_req` = 0) and 435 clocks in pixel mode (`pix_mode_req` = 1).
- R3: `hsy_n` goes low at the start of each line and stays low for the programmed sync width. The nominal width is 32 clocks.
- R4: `h_active` is high from clock 205 through clock 1164 after the `hsy_n` falling edge in dot mode (960 clocks). In pixel mode it is high from clock 84 through clock 403 (320 clocks). While `h_active` is high, `x_pos` starts at 0 and increases by 1 on every clock.
- R5: A frame lasts the programmed number of lines, nominally 262. `vsy_n` stays low for the programmed number of whole lines, nominally 3.
- R6: Each edge of `vsy_n` comes exactly (sync width + floor(line length / 2)) clocks after the falling edge of `hsy_n` that starts the same line. `vsy_n` never changes while `hsy_n` is low.
- R7: Count the falling edges of `hsy_n` after the falling edge of `vsy_n`. `v_active` is high for lines 20 through 253 of that count (234 lines). While `v_active` is high, `y_pos` runs from 0 to 233.
- R8: A write happens when `cfg_we` = 1, on the rising clock edge, using `cfg_wdata`. The address `cfg_addr` selects the target: 0 = dot-mode line length, 1 = pixel-mode line length, 2 = frame length in lines, 3 = horizontal sync width in clocks, 4 = vertical sync width in lines. A write to addresses 5 to 7 changes nothing.
- R9: Each written value is clamped into a legal range. Dot line length is held to 1170 to 1230 and pixel line length to 405 to 465. Frame length is held to 258 to 262 lines, horizontal sync width to 19 to 57 clocks, and vertical sync width to 1 to 5 lines.
- R10: A change of `pix_mode_req` takes effect only at the first line of the next frame. Every line of the current frame keeps the old mode's length and window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; also the panel sample clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_mode_req | input | 1 | Requested mode: 0 dot clocking, 1 pixel clocking |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 11 | Configuration write value |
| hsy_n | output | 1 | Horizontal sync, active low |
| vsy_n | output | 1 | Vertical sync, active low |
| h_active | output | 1 | Inside the horizontal display window |
| v_active | output | 1 | Inside the vertical display window |
| x_pos | output | 11 | Sample index within the horizontal window |
| y_pos | output | 9 | Line index within the vertical window |

## Verification
Several properties are checked on every cycle:
- the horizontal sync low time stays within its clamp range;
- the line period stays within the union of both modes' ranges;
- the vertical sync edges fall only while horizontal sync is high;
- `x_pos` starts at zero and then increases by one per clock;
- `y_pos` starts at zero;
- neither window flag is high during its own sync pulse.

Only the directed scenarios can show the following:
- the exact line and frame lengths, and the window start positions and extents in each mode;
- the half-line launch offset of the vertical sync;
- the clamping of each register and the effect of unused addresses;
- that a mode request waits for the frame boundary.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int HW = 11;  // horizontal counter / config data width
  localparam int VW = 9;   // vertical counter width
  localparam int AW = 3;   // config address width

  typedef enum logic [AW-1:0] {
    REG_LINE_DOT = 3'd0,
    REG_LINE_PIX = 3'd1,
    REG_FRAME    = 3'd2,
    REG_HS_WIDTH = 3'd3,
    REG_VS_WIDTH = 3'd4
  } pt_reg_e;

  typedef struct packed {
    logic [HW-1:0] line_dot;
    logic [HW-1:0] line_pix;
    logic [VW-1:0] frame_len;
    logic [HW-1:0] hs_width;
    logic [VW-1:0] vs_width;
  } pt_cfg_t;

  function automatic logic [HW-1:0] pt_clamp(input logic [HW-1:0] v,
                                             input logic [HW-1:0] lo,
                                             input logic [HW-1:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs
  import pt_pkg::*;
#(
  parameter int DOT_LINE_MIN = 1170,
  parameter int DOT_LINE_NOM = 1200,
  parameter int DOT_LINE_MAX = 1230,
  parameter int PIX_LINE_MIN = 405,
  parameter int PIX_LINE_NOM = 435,
  parameter int PIX_LINE_MAX = 465,
  parameter int FRAME_MIN    = 258,
  parameter int FRAME_NOM    = 262,
  parameter int FRAME_MAX    = 262,
  parameter int HSW_MIN      = 19,
  parameter int HSW_NOM      = 32,
  parameter int HSW_MAX      = 57,
  parameter int VSW_MIN      = 1,
  parameter int VSW_NOM      = 3,
  parameter int VSW_MAX      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [HW-1:0] wdata,
  output pt_cfg_t       cfg
);
  logic [HW-1:0] lo, hi, clamped;

  always_comb begin
    case (addr)
      REG_LINE_DOT: begin lo = HW'(DOT_LINE_MIN); hi = HW'(DOT_LINE_MAX); end
      REG_LINE_PIX: begin lo = HW'(PIX_LINE_MIN); hi = HW'(PIX_LINE_MAX); end
      REG_FRAME:    begin lo = HW'(FRAME_MIN);    hi = HW'(FRAME_MAX);    end
      REG_HS_WIDTH: begin lo = HW'(HSW_MIN);      hi = HW'(HSW_MAX);      end
      REG_VS_WIDTH: begin lo = HW'(VSW_MIN);      hi = HW'(VSW_MAX);      end
      default:      begin lo = '0;                hi = '0;                end
    endcase
    clamped = pt_clamp(wdata, lo, hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.line_dot  <= HW'(DOT_LINE_NOM);
      cfg.line_pix  <= HW'(PIX_LINE_NOM);
      cfg.frame_len <= VW'(FRAME_NOM);
      cfg.hs_width  <= HW'(HSW_NOM);
      cfg.vs_width  <= VW'(VSW_NOM);
    end else if (we) begin
      case (addr)
        REG_LINE_DOT: cfg.line_dot  <= clamped;
        REG_LINE_PIX: cfg.line_pix  <= clamped;
        REG_FRAME:    cfg.frame_len <= clamped[VW-1:0];
        REG_HS_WIDTH: cfg.hs_width  <= clamped;
        REG_VS_WIDTH: cfg.vs_width  <= clamped[VW-1:0];
        default: ;  // unused addresses: no effect
      endcase
    end
  end
endmodule

// File: rtl/pt_counters.sv
module pt_counters
  import pt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_req,
  input  logic [HW-1:0] line_dot,
  input  logic [HW-1:0] line_pix,
  input  logic [VW-1:0] frame_len,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          pix_mode,
  output logic [HW-1:0] line_len
);
  logic h_last, v_last;

  assign line_len = pix_mode ? line_pix : line_dot;
  // >= so a shortened length mid-line or mid-frame still wraps at once
  assign h_last = (h_cnt >= line_len - 1'b1);
  assign v_last = (v_cnt >= frame_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt    <= '0;
      v_cnt    <= '0;
      pix_mode <= mode_req;
    end else if (h_last) begin
      h_cnt <= '0;
      if (v_last) begin
        v_cnt    <= '0;
        pix_mode <= mode_req;  // R10: mode taken only at frame wrap
      end else begin
        v_cnt <= v_cnt + 1'b1;
      end
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pt_timing_out.sv
module pt_timing_out
  import pt_pkg::*;
#(
  parameter int DOT_H_START = 205,
  parameter int DOT_H_LEN   = 960,
  parameter int PIX_H_START = 84,
  parameter int PIX_H_LEN   = 320,
  parameter int V_START     = 20,
  parameter int V_LEN       = 234
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  input  logic          pix_mode,
  input  logic [HW-1:0] line_len,
  input  logic [HW-1:0] hs_width,
  input  logic [VW-1:0] vs_width,
  output logic          hsy_n,
  output logic          vsy_n,
  output logic          h_active,
  output logic          v_active,
  output logic [HW-1:0] x_pos,
  output logic [VW-1:0] y_pos
);
  localparam logic [HW-1:0] DOT_FIRST = HW'(DOT_H_START);
  localparam logic [HW-1:0] DOT_LAST  = HW'(DOT_H_START + DOT_H_LEN - 1);
  localparam logic [HW-1:0] PIX_FIRST = HW'(PIX_H_START);
  localparam logic [HW-1:0] PIX_LAST  = HW'(PIX_H_START + PIX_H_LEN - 1);
  localparam logic [VW-1:0] V_FIRST   = VW'(V_START);
  localparam logic [VW-1:0] V_LAST    = VW'(V_START + V_LEN - 1);

  logic [HW-1:0] h_first, h_lastpos, vs_point;
  logic          h_in, v_in, hs_in, vs_in;

  always_comb begin
    h_first   = pix_mode ? PIX_FIRST : DOT_FIRST;
    h_lastpos = pix_mode ? PIX_LAST  : DOT_LAST;
    h_in      = (h_cnt >= h_first) && (h_cnt <= h_lastpos);
    v_in      = (v_cnt >= V_FIRST) && (v_cnt <= V_LAST);
    hs_in     = (h_cnt < hs_width);
    vs_in     = (v_cnt < vs_width);
    // half a line after the horizontal sync rising edge
    vs_point  = hs_width + {1'b0, line_len[HW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsy_n    <= 1'b1;
      vsy_n    <= 1'b1;
      h_active <= 1'b0;
      v_active <= 1'b0;
      x_pos    <= '0;
      y_pos    <= '0;
    end else begin
      hsy_n    <= ~hs_in;
      if (h_cnt == vs_point) vsy_n <= ~vs_in;
      h_active <= h_in;
      v_active <= v_in;
      x_pos    <= h_in ? h_cnt - h_first : '0;
      y_pos    <= v_in ? v_cnt - V_FIRST : '0;
    end
  end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import pt_pkg::*;
#(
  parameter int DOT_LINE_MIN = 1170,
  parameter int DOT_LINE_NOM = 1200,
  parameter int DOT_LINE_MAX = 1230,
  parameter int PIX_LINE_MIN = 405,
  parameter int PIX_LINE_NOM = 435,
  parameter int PIX_LINE_MAX = 465,
  parameter int FRAME_MIN    = 258,
  parameter int FRAME_NOM    = 262,
  parameter int FRAME_MAX    = 262,
  parameter int HSW_MIN      = 19,
  parameter int HSW_NOM      = 32,
  parameter int HSW_MAX      = 57,
  parameter int VSW_MIN      = 1,
  parameter int VSW_NOM      = 3,
  parameter int VSW_MAX      = 5,
  parameter int DOT_H_START  = 205,
  parameter int DOT_H_LEN    = 960,
  parameter int PIX_H_START  = 84,
  parameter int PIX_H_LEN    = 320,
  parameter int V_START      = 20,
  parameter int V_LEN        = 234
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pix_mode_req,
  input  logic                  cfg_we,
  input  logic [pt_pkg::AW-1:0] cfg_addr,
  input  logic [pt_pkg::HW-1:0] cfg_wdata,
  output logic                  hsy_n,
  output logic                  vsy_n,
  output logic                  h_active,
  output logic                  v_active,
  output logic [pt_pkg::HW-1:0] x_pos,
  output logic [pt_pkg::VW-1:0] y_pos
);
  pt_cfg_t       cfg;
  logic [HW-1:0] h_cnt, line_len;
  logic [VW-1:0] v_cnt;
  logic          pix_mode;

  pt_cfg_regs #(
    .DOT_LINE_MIN(DOT_LINE_MIN), .DOT_LINE_NOM(DOT_LINE_NOM), .DOT_LINE_MAX(DOT_LINE_MAX),
    .PIX_LINE_MIN(PIX_LINE_MIN), .PIX_LINE_NOM(PIX_LINE_NOM), .PIX_LINE_MAX(PIX_LINE_MAX),
    .FRAME_MIN(FRAME_MIN), .FRAME_NOM(FRAME_NOM), .FRAME_MAX(FRAME_MAX),
    .HSW_MIN(HSW_MIN), .HSW_NOM(HSW_NOM), .HSW_MAX(HSW_MAX),
    .VSW_MIN(VSW_MIN), .VSW_NOM(VSW_NOM), .VSW_MAX(VSW_MAX)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .cfg(cfg)
  );

  pt_counters u_cnt (
    .clk(clk), .rst(rst), .mode_req(pix_mode_req),
    .line_dot(cfg.line_dot), .line_pix(cfg.line_pix), .frame_len(cfg.frame_len),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .pix_mode(pix_mode), .line_len(line_len)
  );

  pt_timing_out #(
    .DOT_H_START(DOT_H_START), .DOT_H_LEN(DOT_H_LEN),
    .PIX_H_START(PIX_H_START), .PIX_H_LEN(PIX_H_LEN),
    .V_START(V_START), .V_LEN(V_LEN)
  ) u_out (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .v_cnt(v_cnt), .pix_mode(pix_mode),
    .line_len(line_len), .hs_width(cfg.hs_width), .vs_width(cfg.vs_width),
    .hsy_n(hsy_n), .vsy_n(vsy_n), .h_active(h_active), .v_active(v_active),
    .x_pos(x_pos), .y_pos(y_pos)
  );
endmodule

// File: rtl/pt_checker.sv
module pt_checker
  import pt_pkg::*;
#(
  parameter int HSW_MIN  = 19,
  parameter int HSW_MAX  = 57,
  parameter int LINE_MIN = 405,
  parameter int LINE_MAX = 1230
) (
  input logic          clk,
  input logic          rst,
  input logic          hsy_n,
  input logic          vsy_n,
  input logic          h_active,
  input logic          v_active,
  input logic [HW-1:0] x_pos,
  input logic [VW-1:0] y_pos
);
  localparam logic [HW:0] LO_W = (HW+1)'(HSW_MIN);
  localparam logic [HW:0] HI_W = (HW+1)'(HSW_MAX);
  localparam logic [HW:0] LO_P = (HW+1)'(LINE_MIN);
  localparam logic [HW:0] HI_P = (HW+1)'(LINE_MAX);

  logic [HW:0] low_run, period;
  logic        hs_prev, seen_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run   <= '0;
      period    <= '0;
      hs_prev   <= 1'b1;
      seen_fall <= 1'b0;
    end else begin
      hs_prev <= hsy_n;
      low_run <= hsy_n ? '0 : low_run + 1'b1;
      if (hs_prev && !hsy_n) begin
        period    <= (HW+1)'(1);
        seen_fall <= 1'b1;
      end else if (period != '1) begin
        period <= period + 1'b1;
      end
    end
  end

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (hsy_n && vsy_n && !h_active && !v_active && x_pos == '0 && y_pos == '0));

  a_r3_hsy_width: assert property (@(posedge clk) disable iff (rst)
    $rose(hsy_n) |-> (low_run >= LO_W && low_run <= HI_W));

  a_r2_line_period: assert property (@(posedge clk) disable iff (rst)
    ($fell(hsy_n) && seen_fall) |-> (period >= LO_P && period <= HI_P));

  a_r6_vsy_mid_line: assert property (@(posedge clk) disable iff (rst)
    (vsy_n != $past(vsy_n)) |-> (hsy_n && $past(hsy_n)));

  a_r4_x_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(h_active) |-> x_pos == '0);

  a_r4_x_step: assert property (@(posedge clk) disable iff (rst)
    (h_active && $past(h_active)) |-> x_pos == $past(x_pos) + 1'b1);

  a_r4_h_blank_in_sync: assert property (@(posedge clk) disable iff (rst)
    !hsy_n |-> !h_active);

  a_r7_y_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(v_active) |-> y_pos == '0);

  a_r7_v_blank_in_sync: assert property (@(posedge clk) disable iff (rst)
    !vsy_n |-> !v_active);
endmodule

bind panel_timing_gen pt_checker #(
  .HSW_MIN(HSW_MIN), .HSW_MAX(HSW_MAX),
  .LINE_MIN(PIX_LINE_MIN), .LINE_MAX(DOT_LINE_MAX)
) u_pt_checker (
  .clk(clk), .rst(rst), .hsy_n(hsy_n), .vsy_n(vsy_n),
  .h_active(h_active), .v_active(v_active), .x_pos(x_pos), .y_pos(y_pos)
);

// File: tb/tb_panel_timing_gen.sv
module tb_panel_timing_gen;
  // shortened frame so that whole frames fit the run budget
  localparam int FR_MIN = 12, FR_NOM = 14, FR_MAX = 16;
  localparam int VS0 = 7, VLEN = 4;
  localparam int DOT_NOM = 1200, PIX_NOM = 435, HSW_NOM = 32, VSW_NOM = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_mode_req = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [10:0] cfg_wdata = '0;
  logic        hsy_n, vsy_n, h_active, v_active;
  logic [10:0] x_pos;
  logic [8:0]  y_pos;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  panel_timing_gen #(
    .FRAME_MIN(FR_MIN), .FRAME_NOM(FR_NOM), .FRAME_MAX(FR_MAX),
    .V_START(VS0), .V_LEN(VLEN)
  ) dut (
    .clk(clk), .rst(rst), .pix_mode_req(pix_mode_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .hsy_n(hsy_n), .vsy_n(vsy_n),
    .h_active(h_active), .v_active(v_active), .x_pos(x_pos), .y_pos(y_pos)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 11'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_hfall();
    logic p;
    p = hsy_n;
    forever begin
      @(negedge clk);
      if (p && !hsy_n) return;
      p = hsy_n;
    end
  endtask

  task automatic wait_vfall();
    logic p;
    p = vsy_n;
    forever begin
      @(negedge clk);
      if (p && !vsy_n) return;
      p = vsy_n;
    end
  endtask

  task automatic measure_line(output int per, output int lowc, output int ast,
                              output int alen, output int fx, output int lx);
    int t;
    logic p;
    wait_hfall();
    t = 0; lowc = 0; ast = -1; alen = 0; fx = -1; lx = -1; per = 0;
    forever begin
      if (!hsy_n) lowc++;
      if (h_active) begin
        if (ast < 0) begin ast = t; fx = int'(x_pos); end
        alen++; lx = int'(x_pos);
      end
      p = hsy_n;
      @(negedge clk);
      t++;
      if (p && !hsy_n) begin per = t; return; end
    end
  endtask

  task automatic measure_frame(output int lines, output int off, output int vlow,
                               output int vfirst, output int vcount,
                               output int yfirst, output int ylast);
    int s;
    logic hp, vp;
    wait_hfall();
    s = 0;
    forever begin
      hp = hsy_n; vp = vsy_n;
      @(negedge clk);
      s++;
      if (hp && !hsy_n) s = 0;
      if (vp && !vsy_n) break;
    end
    off = s; lines = 0; vlow = 0; vfirst = -1; vcount = 0; yfirst = -1; ylast = -1;
    forever begin
      if (!vsy_n) vlow++;
      hp = hsy_n; vp = vsy_n;
      @(negedge clk);
      if (hp && !hsy_n) begin
        lines++;
        if (v_active) begin
          if (vfirst < 0) begin vfirst = lines; yfirst = int'(y_pos); end
          vcount++; ylast = int'(y_pos);
        end
      end
      if (vp && !vsy_n) break;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "hsy_n in reset", int'(hsy_n), 1);
    chk("R1", "vsy_n in reset", int'(vsy_n), 1);
    chk("R1", "h_active in reset", int'(h_active), 0);
    chk("R1", "v_active in reset", int'(v_active), 0);
    chk("R1", "x_pos in reset", int'(x_pos), 0);
    chk("R1", "y_pos in reset", int'(y_pos), 0);
    rst = 1'b0;
  endtask

  task automatic t_dot_line();
    int per, lowc, ast, alen, fx, lx;
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R2", "dot line period", per, DOT_NOM);
    chk("R3", "dot hsync width", lowc, HSW_NOM);
    chk("R4", "dot window start", ast, 205);
    chk("R4", "dot window length", alen, 960);
    chk("R4", "dot first x", fx, 0);
    chk("R4", "dot last x", lx, 959);
  endtask

  task automatic t_dot_clamp();
    int per, lowc, ast, alen, fx, lx;
    cfg_write(0, 2000);
    wait_hfall();
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R9", "dot line clamp high", per, 1230);
    cfg_write(0, 100);
    wait_hfall();
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R9", "dot line clamp low", per, 1170);
    cfg_write(0, 1205);
    cfg_write(3, 200);
    wait_hfall();
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R8", "dot line in range", per, 1205);
    chk("R9", "hsync clamp high", lowc, 57);
    cfg_write(3, 3);
    wait_hfall();
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R9", "hsync clamp low", lowc, 19);
    cfg_write(3, 40);
    cfg_write(6, 5);
    cfg_write(7, 300);
    cfg_write(5, 0);
    wait_hfall();
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R8", "hsync in range after unused writes", lowc, 40);
    chk("R8", "line unchanged by unused writes", per, 1205);
    chk("R3", "window start independent of sync width", ast, 205);
    cfg_write(0, DOT_NOM);
    cfg_write(3, HSW_NOM);
  endtask

  task automatic t_dot_frame();
    int lines, off, vlow, vfirst, vcount, yfirst, ylast;
    measure_frame(lines, off, vlow, vfirst, vcount, yfirst, ylast);
    chk("R5", "dot frame lines", lines, FR_NOM);
    chk("R5", "dot vsync low clocks", vlow, VSW_NOM * DOT_NOM);
    chk("R6", "dot vsync offset", off, HSW_NOM + DOT_NOM / 2);
    chk("R7", "first active line", vfirst, VS0);
    chk("R7", "active line count", vcount, VLEN);
    chk("R7", "first y", yfirst, 0);
    chk("R7", "last y", ylast, VLEN - 1);
  endtask

  task automatic t_mode_switch();
    int per, lowc, ast, alen, fx, lx;
    pix_mode_req = 1'b1;  // requested just after a vsync fall: mid-frame
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R10", "line after request keeps dot period", per, DOT_NOM);
    chk("R10", "line after request keeps dot window", ast, 205);
    wait_vfall();
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R10", "pixel period after frame wrap", per, PIX_NOM);
    chk("R2", "pixel line period", per, PIX_NOM);
    chk("R4", "pixel window start", ast, 84);
    chk("R4", "pixel window length", alen, 320);
    chk("R4", "pixel last x", lx, 319);
    chk("R3", "pixel hsync width", lowc, HSW_NOM);
  endtask

  task automatic t_pix_cfg();
    int per, lowc, ast, alen, fx, lx;
    int lines, off, vlow, vfirst, vcount, yfirst, ylast;
    cfg_write(1, 500);
    wait_hfall();
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R9", "pixel line clamp high", per, 465);
    cfg_write(1, 300);
    wait_hfall();
    measure_line(per, lowc, ast, alen, fx, lx);
    chk("R9", "pixel line clamp low", per, 405);
    cfg_write(1, PIX_NOM);
    cfg_write(2, 100);
    cfg_write(4, 9);
    measure_frame(lines, off, vlow, vfirst, vcount, yfirst, ylast);
    chk("R9", "frame clamp high", lines, FR_MAX);
    chk("R9", "vsync clamp high", vlow, 5 * PIX_NOM);
    chk("R6", "pixel vsync offset", off, HSW_NOM + PIX_NOM / 2);
    chk("R7", "pixel active line count", vcount, VLEN);
    cfg_write(2, 0);
    cfg_write(4, 0);
    measure_frame(lines, off, vlow, vfirst, vcount, yfirst, ylast);
    chk("R9", "frame clamp low", lines, FR_MIN);
    chk("R9", "vsync clamp low", vlow, 1 * PIX_NOM);
    chk("R5", "vsync one line frame start", vfirst, VS0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R1..R10 run): got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_dot_line();
    t_dot_clamp();
    t_dot_frame();
    t_mode_switch();
    t_pix_cfg();
    done = 1;
    summary();
    $finish;
  end
endmodule